// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged Load Lookup

This block answers load lookups against a set-associative level-one data cache whose set is picked from address bits that translation leaves untouched. A small fully associative translation buffer converts the virtual page number to a physical page number. This happens in the same cycle as the set read. The physical page number then picks the correct way among the lines of the selected set. Each lookup produces one of three results: a hit, a translation miss or a cache miss. A hit also returns the hitting way and one 32-bit word from the line.

Two fill ports load the block's state. One writes a translation entry, and the block picks the slot in circular order. The other writes a whole line with its physical tag into a set, and the block picks the way from a circular pointer kept per set. The default geometry is 4 KiB pages, 64-byte lines, 8 ways, 64 sets (32 KiB) and 16 translation entries. A geometry whose index and line-offset bits together exceed the page-offset bits is refused at elaboration.

Top module: `vipt_lookup`

## Requirements
- R1: The set index is taken from byte-address bits [11:6] and the word from bits [5:2], both below the 12-bit page offset, and elaboration stops when set bits plus line bits exceed page bits. Two virtual pages mapped to one physical page therefore hit the same line.
- R2: A request driven in one cycle gives `lkValid` and its result flags in the next cycle. `lkValid` is low in any cycle that does not follow a request.
- R3: When no valid translation entry matches the virtual page number, the result is `tlbMiss`=1, `hit`=0 and `cacheMiss`=0, even if a cached line carries a matching physical tag.
- R4: When a valid entry matches and exactly one valid way in the set holds the translated physical page number as its tag, the result is `hit`=1, and `hitWay` gives that way's index.
- R5: When a valid entry matches and no valid way's tag equals the translated page number, the result is `cacheMiss`=1 and `hit`=0.
- R6: When two or more valid ways in the set hold the same matching tag, the lookup reports `cacheMiss`=1, not a hit.
- R7: On a hit, `rdData` is word k of the line, where k is byte-address bits [5:2]. Word k occupies bits [32k+31:32k] of the line fill data.
- R8: Line fills to one set go to ways 0, 1, ..., 7 in turn and then wrap to 0. Each set keeps its own pointer, and every pointer is 0 after reset.
- R9: Translation fills go to entries 0 through 15 in turn and then wrap. The seventeenth fill after reset replaces the first entry and leaves the others in place.
- R10: A synchronous reset clears every translation valid bit and every line valid bit.
- R11: While `lkValid` is 1, exactly one of `hit`, `tlbMiss` and `cacheMiss` is 1. While `lkValid` is 0, all three are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Lookup request strobe |
| reqWordAddr | input | 30 | Virtual word address (byte-address bits [31:2]) |
| tlbFillValid | input | 1 | Write a translation entry |
| tlbFillVpn | input | 20 | Virtual page number to install |
| tlbFillPpn | input | 20 | Physical page number to install |
| lineFillValid | input | 1 | Write a cache line |
| lineFillPpn | input | 20 | Physical tag of the filled line |
| lineFillSet | input | 6 | Set receiving the line |
| lineFillData | input | 512 | Line contents, word k at bits [32k+31:32k] |
| lkValid | output | 1 | Result of the previous cycle's request is present |
| hit | output | 1 | Translation hit and one tag match |
| tlbMiss | output | 1 | No translation entry matched |
| cacheMiss | output | 1 | Translation hit without a single tag match |
| hitWay | output | 3 | Index of the hitting way |
| rdData | output | 32 | Selected word on a hit, zero otherwise |

## Verification
A request is sampled at one rising edge. All of its results (the three flags, the way and the data word) are due in the half-cycle after the next edge, and nothing is due earlier or later. The bench drives each input just after an edge and queues the expected result with the cycle count of that edge. A monitor reads the outputs on the falling edge whenever `lkValid` is high and takes the oldest entry from the queue. It then requires the present cycle count to be exactly one greater than the stored count. Fills take effect at the edge that samples them, so a lookup is driven only after its fills have been sampled.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
  // strobes sent from the control half to the datapath half
  typedef struct packed {
    logic clrValid;
    logic tlbWr;
    logic lineWr;
    logic lookupLive;
  } vipt_strobe_t;
endpackage

// File: rtl/vipt_ctrl.sv
module vipt_ctrl
  import vipt_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int LINE_BITS = 6,
  parameter int SET_BITS  = 6,
  parameter int WAYS      = 8,
  parameter int TLB_N     = 16,
  parameter int WORD_W    = 32
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   reqValid,
  input  logic [VA_W-$clog2(WORD_W/8)-1:0]       reqWordAddr,
  input  logic                                   tlbFillValid,
  input  logic                                   lineFillValid,
  input  logic [SET_BITS-1:0]                    lineFillSet,
  output vipt_strobe_t                           stb,
  output logic [VA_W-PAGE_BITS-1:0]              lkVpn,
  output logic [SET_BITS-1:0]                    lkSet,
  output logic [LINE_BITS-$clog2(WORD_W/8)-1:0]  lkWord,
  output logic [$clog2(TLB_N)-1:0]               tlbWrIdx,
  output logic [$clog2(WAYS)-1:0]                lineWrWay
);
  localparam int WBYTE_BITS = $clog2(WORD_W / 8);
  localparam int WA_W       = VA_W - WBYTE_BITS;
  localparam int VPN_W      = VA_W - PAGE_BITS;
  localparam int SETS       = 1 << SET_BITS;
  localparam int TIDX_W     = $clog2(TLB_N);
  localparam int WAY_W      = $clog2(WAYS);
  localparam logic [TIDX_W-1:0] TLB_LAST = TIDX_W'(TLB_N - 1);
  localparam logic [WAY_W-1:0]  WAY_LAST = WAY_W'(WAYS - 1);

  logic              reqQ;
  logic [WA_W-1:0]   addrQ;
  logic [TIDX_W-1:0] tlbPtr;
  logic [WAY_W-1:0]  wayPtr [SETS];

  // request register: one cycle from request to result
  always_ff @(posedge clk) begin
    if (rst) begin
      reqQ <= 1'b0;
    end else begin
      reqQ <= reqValid;
    end
    if (reqValid) addrQ <= reqWordAddr;
  end

  // circular replacement pointers
  always_ff @(posedge clk) begin
    if (rst) begin
      tlbPtr <= '0;
      for (int s = 0; s < SETS; s++) wayPtr[s] <= '0;
    end else begin
      if (tlbFillValid)
        tlbPtr <= (tlbPtr == TLB_LAST) ? '0 : tlbPtr + 1'b1;
      if (lineFillValid)
        wayPtr[lineFillSet] <= (wayPtr[lineFillSet] == WAY_LAST) ? '0
                                : wayPtr[lineFillSet] + 1'b1;
    end
  end

  always_comb begin
    stb.clrValid   = rst;
    stb.tlbWr      = tlbFillValid & ~rst;
    stb.lineWr     = lineFillValid & ~rst;
    stb.lookupLive = reqQ;
  end

  assign tlbWrIdx  = tlbPtr;
  assign lineWrWay = wayPtr[lineFillSet];
  assign lkWord    = addrQ[LINE_BITS-WBYTE_BITS-1:0];
  assign lkSet     = addrQ[LINE_BITS-WBYTE_BITS +: SET_BITS];
  assign lkVpn     = addrQ[PAGE_BITS-WBYTE_BITS +: VPN_W];
endmodule

// File: rtl/vipt_datapath.sv
module vipt_datapath
  import vipt_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int LINE_BITS = 6,
  parameter int SET_BITS  = 6,
  parameter int WAYS      = 8,
  parameter int TLB_N     = 16,
  parameter int WORD_W    = 32
) (
  input  logic                                   clk,
  input  vipt_strobe_t                           stb,
  input  logic [$clog2(TLB_N)-1:0]               tlbWrIdx,
  input  logic [VA_W-PAGE_BITS-1:0]              tlbFillVpn,
  input  logic [PA_W-PAGE_BITS-1:0]              tlbFillPpn,
  input  logic [$clog2(WAYS)-1:0]                lineWrWay,
  input  logic [SET_BITS-1:0]                    lineFillSet,
  input  logic [PA_W-PAGE_BITS-1:0]              lineFillPpn,
  input  logic [(8<<LINE_BITS)-1:0]              lineFillData,
  input  logic [VA_W-PAGE_BITS-1:0]              lkVpn,
  input  logic [SET_BITS-1:0]                    lkSet,
  input  logic [LINE_BITS-$clog2(WORD_W/8)-1:0]  lkWord,
  output logic                                   hit,
  output logic                                   tlbMiss,
  output logic                                   cacheMiss,
  output logic [$clog2(WAYS)-1:0]                hitWay,
  output logic [WORD_W-1:0]                      rdData
);
  localparam int VPN_W  = VA_W - PAGE_BITS;
  localparam int PPN_W  = PA_W - PAGE_BITS;
  localparam int LINE_W = 8 << LINE_BITS;
  localparam int SETS   = 1 << SET_BITS;
  localparam int WAY_W  = $clog2(WAYS);

  // translation entries
  logic [TLB_N-1:0] tlbValid;
  logic [VPN_W-1:0] tlbVpn [TLB_N];
  logic [PPN_W-1:0] tlbPpn [TLB_N];

  // cache arrays
  logic [WAYS-1:0]   lineValid [SETS];
  logic [PPN_W-1:0]  tagArr    [SETS][WAYS];
  logic [LINE_W-1:0] dataArr   [SETS][WAYS];

  always_ff @(posedge clk) begin
    if (stb.clrValid) begin
      tlbValid <= '0;
      for (int s = 0; s < SETS; s++) lineValid[s] <= '0;
    end else begin
      if (stb.tlbWr)  tlbValid[tlbWrIdx] <= 1'b1;
      if (stb.lineWr) lineValid[lineFillSet][lineWrWay] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (stb.tlbWr) begin
      tlbVpn[tlbWrIdx] <= tlbFillVpn;
      tlbPpn[tlbWrIdx] <= tlbFillPpn;
    end
    if (stb.lineWr) begin
      tagArr[lineFillSet][lineWrWay]  <= lineFillPpn;
      dataArr[lineFillSet][lineWrWay] <= lineFillData;
    end
  end

  // translation compare, all entries at once
  logic [TLB_N-1:0] tlbMatch;
  for (genvar t = 0; t < TLB_N; t++) begin : g_tlbCmp
    assign tlbMatch[t] = tlbValid[t] && (tlbVpn[t] == lkVpn);
  end

  logic             tlbHit;
  logic [PPN_W-1:0] xlatPpn;
  always_comb begin
    xlatPpn = '0;
    for (int t = TLB_N - 1; t >= 0; t--)
      if (tlbMatch[t]) xlatPpn = tlbPpn[t];
  end
  assign tlbHit = |tlbMatch;

  // physical tag compare across the set read in parallel
  logic [WAYS-1:0] wayHit;
  for (genvar w = 0; w < WAYS; w++) begin : g_tagCmp
    assign wayHit[w] = lineValid[lkSet][w] && (tagArr[lkSet][w] == xlatPpn);
  end

  logic             singleHit;
  logic [WAY_W-1:0] hitIdx;
  assign singleHit = (wayHit != '0) && ((wayHit & (wayHit - 1'b1)) == '0);
  always_comb begin
    hitIdx = '0;
    for (int w = 0; w < WAYS; w++)
      if (wayHit[w]) hitIdx = WAY_W'(w);
  end

  logic [LINE_W-1:0] selLine;
  assign selLine = dataArr[lkSet][hitIdx];

  assign hit       = stb.lookupLive & tlbHit & singleHit;
  assign tlbMiss   = stb.lookupLive & ~tlbHit;
  assign cacheMiss = stb.lookupLive & tlbHit & ~singleHit;
  assign hitWay    = hit ? hitIdx : '0;
  assign rdData    = hit ? selLine[lkWord*WORD_W +: WORD_W] : '0;
endmodule

// File: rtl/vipt_lookup.sv
module vipt_lookup
  import vipt_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int LINE_BITS = 6,
  parameter int SET_BITS  = 6,
  parameter int WAYS      = 8,
  parameter int TLB_N     = 16,
  parameter int WORD_W    = 32
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              reqValid,
  input  logic [VA_W-$clog2(WORD_W/8)-1:0]  reqWordAddr,
  input  logic                              tlbFillValid,
  input  logic [VA_W-PAGE_BITS-1:0]         tlbFillVpn,
  input  logic [PA_W-PAGE_BITS-1:0]         tlbFillPpn,
  input  logic                              lineFillValid,
  input  logic [PA_W-PAGE_BITS-1:0]         lineFillPpn,
  input  logic [SET_BITS-1:0]               lineFillSet,
  input  logic [(8<<LINE_BITS)-1:0]         lineFillData,
  output logic                              lkValid,
  output logic                              hit,
  output logic                              tlbMiss,
  output logic                              cacheMiss,
  output logic [$clog2(WAYS)-1:0]           hitWay,
  output logic [WORD_W-1:0]                 rdData
);
  localparam int VPN_W  = VA_W - PAGE_BITS;
  localparam int WSEL_W = LINE_BITS - $clog2(WORD_W / 8);

  // R1: the set index must sit inside the untranslated page offset
  if (SET_BITS + LINE_BITS > PAGE_BITS) begin : g_geomCheck
    $error("set index and line offset exceed the page offset");
  end

  vipt_strobe_t              stb;
  logic [VPN_W-1:0]          lkVpn;
  logic [SET_BITS-1:0]       lkSet;
  logic [WSEL_W-1:0]         lkWord;
  logic [$clog2(TLB_N)-1:0]  tlbWrIdx;
  logic [$clog2(WAYS)-1:0]   lineWrWay;

  vipt_ctrl #(
    .VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .LINE_BITS(LINE_BITS),
    .SET_BITS(SET_BITS), .WAYS(WAYS), .TLB_N(TLB_N), .WORD_W(WORD_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWordAddr(reqWordAddr),
    .tlbFillValid(tlbFillValid), .lineFillValid(lineFillValid),
    .lineFillSet(lineFillSet), .stb(stb), .lkVpn(lkVpn), .lkSet(lkSet),
    .lkWord(lkWord), .tlbWrIdx(tlbWrIdx), .lineWrWay(lineWrWay)
  );

  vipt_datapath #(
    .VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS), .LINE_BITS(LINE_BITS),
    .SET_BITS(SET_BITS), .WAYS(WAYS), .TLB_N(TLB_N), .WORD_W(WORD_W)
  ) u_dp (
    .clk(clk), .stb(stb), .tlbWrIdx(tlbWrIdx), .tlbFillVpn(tlbFillVpn),
    .tlbFillPpn(tlbFillPpn), .lineWrWay(lineWrWay), .lineFillSet(lineFillSet),
    .lineFillPpn(lineFillPpn), .lineFillData(lineFillData), .lkVpn(lkVpn),
    .lkSet(lkSet), .lkWord(lkWord), .hit(hit), .tlbMiss(tlbMiss),
    .cacheMiss(cacheMiss), .hitWay(hitWay), .rdData(rdData)
  );

  assign lkValid = stb.lookupLive;
endmodule

// File: rtl/vipt_lookup_chk.sv
module vipt_lookup_chk (
  input logic clk,
  input logic rst,
  input logic reqValid,
  input logic lkValid,
  input logic hit,
  input logic tlbMiss,
  input logic cacheMiss
);
  p_one_flag_r11: assert property (@(posedge clk) disable iff (rst)
    lkValid |-> $countones({hit, tlbMiss, cacheMiss}) == 1);

  p_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !lkValid |-> !(hit || tlbMiss || cacheMiss));

  p_result_due_r2: assert property (@(posedge clk) disable iff (rst)
    reqValid |=> lkValid);

  p_no_spurious_r2: assert property (@(posedge clk) disable iff (rst)
    !reqValid |=> !lkValid);
endmodule

bind vipt_lookup vipt_lookup_chk u_chk (
  .clk(clk), .rst(rst), .reqValid(reqValid), .lkValid(lkValid),
  .hit(hit), .tlbMiss(tlbMiss), .cacheMiss(cacheMiss)
);

// File: tb/test_vipt_lookup.sv
`timescale 1ns/1ps
module test_vipt_lookup;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         reqValid = 1'b0;
  logic [29:0]  reqWordAddr = '0;
  logic         tlbFillValid = 1'b0;
  logic [19:0]  tlbFillVpn = '0;
  logic [19:0]  tlbFillPpn = '0;
  logic         lineFillValid = 1'b0;
  logic [19:0]  lineFillPpn = '0;
  logic [5:0]   lineFillSet = '0;
  logic [511:0] lineFillData = '0;
  logic         lkValid, hit, tlbMiss, cacheMiss;
  logic [2:0]   hitWay;
  logic [31:0]  rdData;

  vipt_lookup i_vipt_lookup (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWordAddr(reqWordAddr),
    .tlbFillValid(tlbFillValid), .tlbFillVpn(tlbFillVpn), .tlbFillPpn(tlbFillPpn),
    .lineFillValid(lineFillValid), .lineFillPpn(lineFillPpn),
    .lineFillSet(lineFillSet), .lineFillData(lineFillData),
    .lkValid(lkValid), .hit(hit), .tlbMiss(tlbMiss), .cacheMiss(cacheMiss),
    .hitWay(hitWay), .rdData(rdData)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  localparam int K_HIT = 0, K_TMISS = 1, K_CMISS = 2;

  typedef struct {
    logic [31:0] va;
    int          kind;
    int          way;
    logic [31:0] data;
    string       tag;
    longint      pushCyc;
  } exp_t;
  exp_t expQ[$];

  function automatic logic [31:0] mkWord(int seed, int k);
    return 32'hA500_0000 ^ (32'(seed) << 8) ^ 32'(k);
  endfunction

  function automatic logic [511:0] mkLine(int seed);
    logic [511:0] l;
    for (int k = 0; k < 16; k++) l[k*32 +: 32] = mkWord(seed, k);
    return l;
  endfunction

  task automatic tlbFill(input logic [19:0] vpn, input logic [19:0] ppn);
    @(posedge clk); #1;
    tlbFillValid = 1'b1; tlbFillVpn = vpn; tlbFillPpn = ppn;
    @(posedge clk); #1;
    tlbFillValid = 1'b0;
  endtask

  task automatic lineFill(input logic [19:0] ppn, input logic [5:0] set, input int seed);
    @(posedge clk); #1;
    lineFillValid = 1'b1; lineFillPpn = ppn; lineFillSet = set;
    lineFillData = mkLine(seed);
    @(posedge clk); #1;
    lineFillValid = 1'b0;
  endtask

  // byte address in, expected result queued for the monitor
  task automatic lookup(input logic [31:0] va, input int kind, input int way,
                        input int seed, input string tag);
    exp_t e;
    @(posedge clk); #1;
    reqValid = 1'b1; reqWordAddr = va[31:2];
    e.va = va; e.kind = kind; e.way = way; e.tag = tag; e.pushCyc = cyc;
    e.data = (kind == K_HIT) ? mkWord(seed, int'(va[5:2])) : 32'h0;
    expQ.push_back(e);
    @(posedge clk); #1;
    reqValid = 1'b0;
  endtask

  // monitor: results are due one edge after the sampling edge
  always @(negedge clk) begin
    if (!rst) begin
      if (!lkValid && (hit || tlbMiss || cacheMiss)) begin
        checks++; fails++;
        $display("FAIL R11 flags without lkValid: actual %b%b%b expected 000",
                 hit, tlbMiss, cacheMiss);
      end
      if (lkValid) begin
        if (expQ.size() == 0) begin
          checks++; fails++;
          $display("FAIL R2 unexpected lkValid: actual 1 expected 0");
        end else begin
          exp_t e;
          logic [2:0] expFlags, gotFlags;
          e = expQ.pop_front();
          checks++;
          expFlags = {e.kind == K_HIT, e.kind == K_TMISS, e.kind == K_CMISS};
          gotFlags = {hit, tlbMiss, cacheMiss};
          if (cyc != e.pushCyc + 1) begin
            fails++;
            $display("FAIL R2 va %h latency: actual %0d expected %0d",
                     e.va, cyc - e.pushCyc, 1);
          end else if (gotFlags !== expFlags) begin
            fails++;
            $display("FAIL %s va %h flags hit/tlbMiss/cacheMiss: actual %b expected %b",
                     e.tag, e.va, gotFlags, expFlags);
          end else if (e.kind == K_HIT && (hitWay !== 3'(e.way) || rdData !== e.data)) begin
            fails++;
            $display("FAIL %s va %h way/data: actual %0d/%h expected %0d/%h",
                     e.tag, e.va, hitWay, rdData, e.way, e.data);
          end
        end
      end
    end
  end

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    checks++; // R10 R11: nothing reported after reset
    if ({lkValid, hit, tlbMiss, cacheMiss} !== 4'b0000) begin
      fails++;
      $display("FAIL R10 reset outputs: actual %b expected 0000",
               {lkValid, hit, tlbMiss, cacheMiss});
    end

    lookup(32'h1234_56C8, K_TMISS, 0, 0, "R10");           // empty translation buffer
    tlbFill(20'h12345, 20'hABCDE);                           // entry 0
    lookup(32'h1234_56C8, K_CMISS, 0, 0, "R5");
    lineFill(20'hABCDE, 6'd27, 1);                           // set 27 way 0
    lookup(32'h1234_56C8, K_HIT, 0, 1, "R4");                // word 2
    lookup(32'h1234_56FC, K_HIT, 0, 1, "R7");                // word 15
    lookup(32'h1234_56C0, K_HIT, 0, 1, "R7");                // word 0
    tlbFill(20'h00777, 20'hABCDE);                           // entry 1, alias
    lookup(32'h0077_76C8, K_HIT, 0, 1, "R1");

    for (int j = 1; j <= 7; j++) lineFill(20'h10000 + 20'(j), 6'd27, 10 + j); // ways 1..7
    tlbFill(20'h40001, 20'h10001);                           // entry 2
    tlbFill(20'h40007, 20'h10007);                           // entry 3
    lookup(32'h4000_16C8, K_HIT, 1, 11, "R8");
    lookup(32'h4000_76C8, K_HIT, 7, 17, "R8");
    lineFill(20'h10009, 6'd27, 19);                          // wraps to way 0
    lookup(32'h1234_56C8, K_CMISS, 0, 0, "R8");
    lineFill(20'hABCDE, 6'd5, 2);                            // set 5 pointer still 0
    lookup(32'h1234_5140, K_HIT, 0, 2, "R8");
    lineFill(20'hABCDE, 6'd5, 3);                            // duplicate tag, way 1
    lookup(32'h1234_5144, K_CMISS, 0, 0, "R6");

    for (int i = 0; i < 12; i++) tlbFill(20'h50000 + 20'(i), 20'h60000 + 20'(i)); // entries 4..15
    tlbFill(20'h5FFFF, 20'h7FFFF);                           // replaces entry 0
    lookup(32'h1234_5140, K_TMISS, 0, 0, "R9");
    lookup(32'h1234_5140, K_TMISS, 0, 0, "R3");              // lines tagged ABCDE still valid
    lookup(32'h0077_7140, K_CMISS, 0, 0, "R9");              // entry 1 survives
    lookup(32'h5000_0000, K_CMISS, 0, 0, "R9");
    tlbFill(20'h5FFFE, 20'h7FFFE);                           // replaces entry 1
    lookup(32'h0077_7140, K_TMISS, 0, 0, "R9");

    @(posedge clk); #1 rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    lookup(32'h4000_16C8, K_TMISS, 0, 0, "R10");
    tlbFill(20'h40001, 20'h10001);
    lookup(32'h4000_16C8, K_CMISS, 0, 0, "R10");
    lineFill(20'h10001, 6'd27, 77);                          // pointer back to way 0
    lookup(32'h4000_16FC, K_HIT, 0, 77, "R8");

    repeat (4) @(posedge clk);
    checks++;
    if (expQ.size() != 0) begin
      fails++;
      $display("FAIL R2 results outstanding: actual %0d expected 0", expQ.size());
    end
    finishRun();
  end
endmodule